// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block takes the demodulated output of an infrared receiver module and records the length of each mark (active) and gap (inactive) period as it arrives. The line is first brought into the core clock domain. It is then sampled once per programmable sampling interval. Each run of equal samples becomes an 8-bit width, counted in samples. Widths go into a bank of 17 capture words, four widths per word. Software reads the bank and decodes the protocol. Protocol decoding is not part of this block.

A message ends when a gap lasts for a programmable number of samples. That final gap is stored as the marker value 0xFF. A message also ends when the bank has no free slot left, in which case the message is truncated. Either ending freezes the bank and sets a pending flag. The pending flag drives a maskable interrupt. Writing the restart command empties the bank and rearms the receiver. The pending flag is cleared only by its own clear command.

Software reaches the block through a word-addressed register port. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A read answers on the next cycle with `rsp_valid`. The response stays on `rsp_valid` and `rsp_data` without change until a cycle with `rsp_ready` high. While a response is waiting and `rsp_ready` is low, `req_ready` is low and no request is taken. Writes produce no response.

Top module: `ir_capture_ctrl`

## Requirements
- R1: After reset `irq` is low and every capture word reads 0. The control register at 0x00 reads 0x00C80000, which is a completion count of 200 with both enables clear. The period register at 0x04 reads 0x000008FB. The interrupt enable register at 0x0C and the status register at 0x10 read 0.
- R2: Sampling runs only while bit 0 (receiver enable) and bit 13 (width-measurement enable) of register 0x00 are both set. One sample is taken every DIV+1 clocks, where DIV is register 0x04 bits [15:0]. With either enable bit clear, nothing is captured and no interrupt arises.
- R3: The raw input is active-low and passes through a two-flop synchronizer. Capture starts only on the first active sample that follows an inactive sample. An active level that is already present when the receiver is armed is not recorded, and neither is leading idle time. Entry 0 is always a mark.
- R4: Entries alternate strictly between mark and gap. Each entry holds the number of samples in its run. A mark longer than 255 samples is stored as 0xFF.
- R5: Entry j is stored in capture word j/4, at byte address 0x40 + 4*(j/4), in bits [8*(j%4)+7 : 8*(j%4)]. The earliest entry of a word sits in its lowest byte.
- R6: A gap that reaches L samples ends the message and is stored as 0xFF. L is register 0x00 bits [23:16], and a value of 0 means 255. Usable values are 2 to 255.
- R7: When entry 67 has been stored, the message ends as truncated. The interrupt is raised in the same way as for a normal ending.
- R8: After a message has ended, the capture words stay unchanged and further input edges are ignored until a restart.
- R9: Writing 1 to bit 0 of register 0x08 clears all capture words and rearms the receiver. The pending flag is not affected.
- R10: The pending flag reads back at register 0x10 bit 0. Writing 1 to that bit clears the flag. `irq` equals the pending flag ANDed with register 0x0C bit 0.
- R11: Read data appears one cycle after the request is taken. It is held stable until `rsp_ready` is high, and `req_ready` stays low while an unconsumed response is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver output, active-low, asynchronous |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | Message-complete interrupt, level |

## Verification
The embedded properties assume the requester obeys the response handshake. They also assume the sampling divider is not lowered while the receiver runs, because the tick-spacing property depends on a steady divider. The bench sets the divider before it sets the enables and leaves it alone afterwards. The bench changes the infrared line only on falling clock edges, in runs that are whole multiples of the sampling interval, so each run maps to a definite width. The completion count in the stimulus is always at least 2, and the bench holds `rsp_ready` low only in the back-pressure test.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ENTRY_W   = 8;
  localparam int unsigned PER_WORD  = WORD_W / ENTRY_W;

  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_PERIOD   = 8'h04;
  localparam logic [ADDR_W-1:0] A_RESTART  = 8'h08;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] A_CAP_BASE = 8'h40;

  localparam int unsigned CTRL_RX_BIT   = 0;
  localparam int unsigned CTRL_MEAS_BIT = 13;
  localparam int unsigned CTRL_LIM_LSB  = 16;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_act
);
  localparam logic IDLE_LVL = ACTIVE_LOW;

  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE_LVL;
      sync_q <= IDLE_LVL;
    end else begin
      meta_q <= line_raw;
      sync_q <= meta_q;
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_inv
      assign line_act = ~sync_q;
    end else begin : g_pass
      assign line_act = sync_q;
    end
  endgenerate
endmodule

// File: rtl/ir_cap_prescaler.sv
module ir_cap_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_en && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_en || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a nonzero divider two samples never fall on adjacent clocks
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/ir_cap_engine.sv
module ir_cap_engine
  import ir_cap_pkg::*;
#(
  parameter int unsigned NWORDS = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       act,
  input  logic                       restart,
  input  logic [ENTRY_W-1:0]         lim,
  output logic [NWORDS*WORD_W-1:0]   words_o,
  output logic                       done_pulse
);
  localparam int unsigned NSLOT = NWORDS * PER_WORD;
  localparam int unsigned IDX_W = $clog2(NSLOT);
  localparam int unsigned POS_W = $clog2(NSLOT * ENTRY_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);
  localparam logic [ENTRY_W-1:0] SAT = '1;

  cap_state_e          st_q, st_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [ENTRY_W-1:0]  wid_q, wid_d;
  logic                lvl_q, lvl_d;
  logic                wr_en;
  logic [ENTRY_W-1:0]  wr_val;
  logic [ENTRY_W-1:0]  lim_eff;
  logic [NSLOT*ENTRY_W-1:0] slots_q;
  logic [POS_W-1:0]    wr_pos;

  assign lim_eff = (lim == '0) ? SAT : lim;
  assign wr_pos  = POS_W'(idx_q) << $clog2(ENTRY_W);

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    wid_d      = wid_q;
    lvl_d      = lvl_q;
    wr_en      = 1'b0;
    wr_val     = wid_q;
    done_pulse = 1'b0;
    if (restart) begin
      st_d  = ST_WAIT;
      idx_d = '0;
      wid_d = '0;
      lvl_d = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        ST_WAIT: if (!act) st_d = ST_ARMED;
        ST_ARMED: if (act) begin
          st_d  = ST_RUN;
          lvl_d = 1'b1;
          wid_d = ENTRY_W'(1);
          idx_d = '0;
        end
        ST_RUN: begin
          if (act == lvl_q) begin
            if (!lvl_q && ({1'b0, wid_q} + 1'b1 >= {1'b0, lim_eff})) begin
              wr_en      = 1'b1;
              wr_val     = SAT;
              st_d       = ST_DONE;
              done_pulse = 1'b1;
            end else if (wid_q != SAT) begin
              wid_d = wid_q + 1'b1;
            end
          end else begin
            wr_en = 1'b1;
            if (idx_q == LAST_IDX) begin
              st_d       = ST_DONE;
              done_pulse = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
              lvl_d = act;
              wid_d = ENTRY_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      idx_q <= '0;
      wid_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      wid_q <= wid_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slots_q <= '0;
    else if (restart) slots_q <= '0;
    else if (wr_en)   slots_q[wr_pos +: ENTRY_W] <= wr_val;
  end

  assign words_o = slots_q;

  // R7: the write index never leaves the bank while capturing
  a_r7_index_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (idx_q <= LAST_IDX));
  // R9: a restart empties the bank and rearms the receiver
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st_q == ST_WAIT && slots_q == '0));
  // R8: a finished message is frozen until restart
  a_r8_frozen_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !restart) |=> $stable(slots_q));
  // R3: capture begins with a one-sample mark
  a_r3_first_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && $past(st_q) == ST_ARMED) |-> (lvl_q && wid_q == ENTRY_W'(1) && idx_q == '0));
endmodule

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
  import ir_cap_pkg::*;
#(
  parameter int unsigned NWORDS  = 17,
  parameter int unsigned DIV_W   = 16,
  parameter logic [DIV_W-1:0]   DEF_DIV = 16'd2299,
  parameter logic [ENTRY_W-1:0] DEF_LIM = 8'd200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [WORD_W-1:0]        rsp_data,
  input  logic [NWORDS*WORD_W-1:0] words_i,
  input  logic                     done_pulse,
  output logic                     run_en,
  output logic [DIV_W-1:0]         div_o,
  output logic [ENTRY_W-1:0]       lim_o,
  output logic                     restart_o,
  output logic                     irq
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] CAP_W0 = A_CAP_BASE[ADDR_W-1:2];

  logic rx_en_q, meas_en_q, irq_en_q, pend_q;
  logic [ENTRY_W-1:0] lim_q;
  logic [DIV_W-1:0]   div_q;
  logic rsp_valid_q;
  logic [WORD_W-1:0]  rsp_data_q, rd_val;
  logic acc, wr_acc, rd_acc, clr_hit, cap_hit;
  logic [WIDX_W-1:0]  widx;
  logic unused_bits;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign restart_o = wr_acc && (req_addr == A_RESTART) && req_wdata[0];
  assign clr_hit   = wr_acc && (req_addr == A_IRQ_STAT) && req_wdata[0];
  assign widx      = req_addr[ADDR_W-1:2] - CAP_W0;
  assign cap_hit   = (req_addr >= A_CAP_BASE) && (widx < WIDX_W'(NWORDS));
  assign unused_bits = ^{req_addr[1:0], req_wdata[WORD_W-1:CTRL_LIM_LSB+ENTRY_W]};

  always_comb begin
    rd_val = '0;
    unique case (req_addr)
      A_CTRL: begin
        rd_val[CTRL_RX_BIT]   = rx_en_q;
        rd_val[CTRL_MEAS_BIT] = meas_en_q;
        rd_val[CTRL_LIM_LSB +: ENTRY_W] = lim_q;
      end
      A_PERIOD:   rd_val[DIV_W-1:0] = div_q;
      A_IRQ_EN:   rd_val[0] = irq_en_q;
      A_IRQ_STAT: rd_val[0] = pend_q;
      default: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (cap_hit && widx == WIDX_W'(w)) rd_val = words_i[w*WORD_W +: WORD_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      meas_en_q <= 1'b0;
      lim_q     <= DEF_LIM;
      div_q     <= DEF_DIV;
      irq_en_q  <= 1'b0;
    end else if (wr_acc) begin
      unique case (req_addr)
        A_CTRL: begin
          rx_en_q   <= req_wdata[CTRL_RX_BIT];
          meas_en_q <= req_wdata[CTRL_MEAS_BIT];
          lim_q     <= req_wdata[CTRL_LIM_LSB +: ENTRY_W];
        end
        A_PERIOD: div_q    <= req_wdata[DIV_W-1:0];
        A_IRQ_EN: irq_en_q <= req_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (done_pulse) pend_q <= 1'b1;
    else if (clr_hit)    pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign run_en    = rx_en_q && meas_en_q;
  assign div_o     = div_q;
  assign lim_o     = lim_q;
  assign irq       = pend_q && irq_en_q;

  // R11: an unconsumed response is held unchanged
  a_r11_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_data_q)));
  // R10: message completion always leaves the pending flag set
  a_r10_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> pend_q);
  // R9: restart leaves the pending flag alone
  a_r9_restart_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && !clr_hit && !done_pulse) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
  import ir_cap_pkg::*;
#(
  parameter int unsigned NWORDS     = 17,
  parameter int unsigned DIV_W      = 16,
  parameter logic [DIV_W-1:0]   DEF_DIV = 16'd2299,
  parameter logic [ENTRY_W-1:0] DEF_LIM = 8'd200,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        irq
);
  logic line_act, tick, run_en, restart, done_pulse;
  logic [DIV_W-1:0]   div;
  logic [ENTRY_W-1:0] lim;
  logic [NWORDS*WORD_W-1:0] words;

  ir_cap_sync #(.ACTIVE_LOW(ACTIVE_LOW)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_raw(ir_in), .line_act(line_act));

  ir_cap_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_i(div), .tick_o(tick));

  ir_cap_engine #(.NWORDS(NWORDS)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(line_act), .restart(restart),
    .lim(lim), .words_o(words), .done_pulse(done_pulse));

  ir_cap_regs #(.NWORDS(NWORDS), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .DEF_LIM(DEF_LIM)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .words_i(words), .done_pulse(done_pulse), .run_en(run_en), .div_o(div),
    .lim_o(lim), .restart_o(restart), .irq(irq));
endmodule

// File: tb/ir_capture_ctrl_bench.sv
module ir_capture_ctrl_bench;
  localparam int DIV   = 3;
  localparam int NSL   = 68;
  localparam int LIM   = 20;
  localparam int CTRL_ON = (LIM << 16) | (1 << 13) | 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ir_capture_ctrl u_ir_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .irq(irq));

  // behavioural reference model
  int m_mem [NSL];
  int m_st, m_idx, m_wid, m_lvl, m_pc, m_div, m_lim;
  bit m_rx, m_meas, m_irqen, m_pend, m_rv, m_s1, m_s2;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_word(int w);
    return {m_mem[4*w+3][7:0], m_mem[4*w+2][7:0], m_mem[4*w+1][7:0], m_mem[4*w][7:0]};
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return (32'(m_lim) << 16) | (32'(m_meas) << 13) | 32'(m_rx);
    if (a == 8'h04) return 32'(m_div);
    if (a == 8'h0C) return 32'(m_irqen);
    if (a == 8'h10) return 32'(m_pend);
    if (a >= 8'h40 && ((a - 8'h40) >> 2) < 17) return m_word((a - 8'h40) >> 2);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_st = 0; m_idx = 0; m_wid = 0; m_lvl = 0; m_pc = 0; m_div = 2299; m_lim = 200;
      m_rx = 0; m_meas = 0; m_irqen = 0; m_pend = 0; m_rv = 0; m_s1 = 1; m_s2 = 1; m_rd = '0;
    end else begin
      bit acc, wr, restart, clr, tick, act, done;
      int lim_e;
      acc = req_valid && (!m_rv || rsp_ready);
      wr = acc && req_write;
      if (acc && !req_write) begin m_rv = 1; m_rd = m_read(req_addr); end
      else if (rsp_ready) m_rv = 0;
      restart = wr && req_addr == 8'h08 && req_wdata[0];
      clr = wr && req_addr == 8'h10 && req_wdata[0];
      tick = m_rx && m_meas && m_pc == m_div;
      act = !m_s2;
      done = 0;
      lim_e = (m_lim == 0) ? 255 : m_lim;
      if (restart) begin
        foreach (m_mem[i]) m_mem[i] = 0;
        m_st = 0; m_idx = 0; m_wid = 0; m_lvl = 0;
      end else if (tick) begin
        case (m_st)
          0: if (!act) m_st = 1;
          1: if (act) begin m_st = 2; m_lvl = 1; m_wid = 1; m_idx = 0; end
          2: if (int'(act) == m_lvl) begin
               if (m_lvl == 0 && m_wid + 1 >= lim_e) begin
                 m_mem[m_idx] = 255; m_st = 3; done = 1;
               end else if (m_wid < 255) m_wid++;
             end else begin
               m_mem[m_idx] = m_wid;
               if (m_idx == NSL - 1) begin m_st = 3; done = 1; end
               else begin m_idx++; m_lvl = act; m_wid = 1; end
             end
          default: ;
        endcase
      end
      if (done) m_pend = 1; else if (clr) m_pend = 0;
      if (!(m_rx && m_meas) || tick) m_pc = 0; else m_pc++;
      m_s2 = m_s1; m_s1 = ir_in;
      if (wr && req_addr == 8'h00) begin
        m_rx = req_wdata[0]; m_meas = req_wdata[13]; m_lim = int'(req_wdata[23:16]);
      end
      if (wr && req_addr == 8'h04) m_div = int'(req_wdata[15:0]);
      if (wr && req_addr == 8'h0C) m_irqen = req_wdata[0];
    end
  end

  task automatic check(logic [31:0] act_v, logic [31:0] exp_v, string tag);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(32'(irq), 32'(m_pend && m_irqen), "R10 irq vs model");
      check(32'(rsp_valid), 32'(m_rv), "R11 rsp_valid vs model");
      check(32'(req_ready), 32'(!m_rv || rsp_ready), "R11 req_ready vs model");
      if (m_rv) check(rsp_data, m_rd, "R5 rsp_data vs model");
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp_v, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_data, exp_v, tag);
  endtask

  task automatic line(bit active, int samples);
    ir_in = active ? 1'b0 : 1'b1;
    repeat (samples * (DIV + 1)) @(negedge clk);
  endtask

  task automatic rearm();
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(32'(irq), 0, "R1 irq after reset");
    rd(8'h00, 32'h00C80000, "R1 ctrl default");
    rd(8'h04, 32'h000008FB, "R1 period default");
    rd(8'h10, 32'h0, "R1 status default");
    rd(8'h40, 32'h0, "R1 word0 default");
    rd(8'h80, 32'h0, "R1 word16 default");

    wr(8'h04, DIV);
    wr(8'h0C, 32'h1);
    // R2: only receiver enable set, measurement off
    wr(8'h00, (LIM << 16) | 1);
    line(0, 3); line(1, 5); line(0, 30);
    rd(8'h40, 32'h0, "R2 no capture with measure disabled");
    check(32'(irq), 0, "R2 no irq with measure disabled");

    // R3 R4 R5 R6: normal message, line active when armed is ignored
    ir_in = 1'b0;
    wr(8'h00, CTRL_ON);
    line(1, 6); line(0, 3);
    line(1, 9); line(0, 4); line(1, 3); line(0, 30);
    rd(8'h40, 32'hFF030409, "R5 R6 word0 packing and end marker");
    rd(8'h44, 32'h0, "R3 no leading active entry");
    check(32'(irq), 1, "R10 irq after completion");
    rd(8'h10, 32'h1, "R10 pending readable");

    // R8: edges after completion are ignored
    line(1, 5); line(0, 5); line(1, 5); line(0, 30);
    rd(8'h40, 32'hFF030409, "R8 word0 frozen");
    rd(8'h44, 32'h0, "R8 word1 untouched");

    // R10 masking, R9 restart keeps pending
    wr(8'h0C, 32'h0);
    check(32'(irq), 0, "R10 irq masked");
    wr(8'h0C, 32'h1);
    wr(8'h08, 32'h1);
    check(32'(irq), 1, "R9 pending survives restart");
    rd(8'h40, 32'h0, "R9 restart clears words");
    wr(8'h10, 32'h1);
    check(32'(irq), 0, "R10 clear drops irq");

    // R4 saturation of a long mark
    line(0, 4); line(1, 300); line(0, 5); line(1, 2); line(0, 30);
    rd(8'h40, 32'hFF0205FF, "R4 saturated mark");
    rearm();

    // R7 truncation after 68 entries
    line(0, 4);
    for (int k = 0; k < 40; k++) begin line(1, 2); line(0, 3); end
    line(0, 30);
    rd(8'h40, 32'h03020302, "R7 first word");
    rd(8'h80, 32'h03020302, "R7 last word");
    check(32'(irq), 1, "R7 truncation raises irq");
    rearm();

    // R11 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h00;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(32'(rsp_valid), 1, "R11 response held");
    check(rsp_data, CTRL_ON, "R11 held data");
    check(32'(req_ready), 0, "R11 request stalled");
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(32'(rsp_valid), 0, "R11 response consumed");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule